// File: doc/BRIEF.md
# Warp Issue Cycle Classifier

This block sits beside one warp scheduler and accounts for every issue slot. In each enabled cycle it takes the scheduler's status flags and places the slot in exactly one of eight categories. The flags are: whether any warp holds a valid instruction, whether warps wait at barriers or on atomics, whether a ready warp failed its scoreboard check, whether a warp issued, and how many threads of the issuing warp are active. The categories are full issue, divergent issue, scoreboard hazard, pipe stall, synchronization barrier, memory barrier, atomic wait and control hazard.

A fixed priority decision tree picks the category. The first question is whether any valid instruction exists. With none, the slot is idle: the barrier and atomic reasons are tested in a fixed order, and anything left over counts as a control hazard. With valid work, the tree separates full issue from divergent issue, and a missed issue caused by a scoreboard failure from one caused by a busy functional unit. The chosen category appears as a one-hot vector in the same cycle.

Each category drives its own saturating event counter. Software-side logic reads a counter by index and gets the value on a registered output. A synchronous clear zeroes all counters, and an enable input gates counting.

Top module: `issue_slot_classifier`

## Requirements
- R1: While `count_en` is high, `slot_cat` has exactly one bit set. While it is low, `slot_cat` is all zeros and no counter changes.
- R2: With `any_valid` low, the idle reason follows a fixed priority: `sync_wait` selects bit 0, else `membar_wait` selects bit 1, else `atomic_wait` selects bit 2.
- R3: With `any_valid` low and none of the three wait flags set, the slot is a control hazard (bit 3).
- R4: With `any_valid` and `issued` both high and `active_thr` greater than or equal to THREADS, the slot is a full issue (bit 4). The wait flags are ignored.
- R5: With `any_valid` and `issued` both high and `active_thr` below THREADS, the slot is a divergent issue (bit 5).
- R6: With `any_valid` high, `issued` low and `sb_fail` high, the slot is a scoreboard hazard (bit 6). `sb_fail` is ignored whenever `issued` is high.
- R7: With `any_valid` high and both `issued` and `sb_fail` low, the slot is a pipe stall (bit 7).
- R8: Each edge at which a category bit is set and `cnt_clr` is low increments that category's counter by one. A counter holds once it reaches 2^CNT_W-1.
- R9: `cnt_clr` zeroes all counters at the next edge. It takes priority over counting and acts whether or not `count_en` is high.
- R10: At each edge, `rd_data` takes the value that the counter selected by `rd_idx` held just before that edge. After reset, `rd_data` and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_en | input | 1 | Enables classification and counting |
| cnt_clr | input | 1 | Synchronous clear of all counters |
| any_valid | input | 1 | Some warp holds a valid instruction |
| sync_wait | input | 1 | Some warp waits at a synchronization barrier |
| membar_wait | input | 1 | Some warp waits at a memory barrier |
| atomic_wait | input | 1 | Some warp is stalled on an atomic |
| sb_fail | input | 1 | A ready warp failed the scoreboard check |
| issued | input | 1 | A warp issued this cycle |
| active_thr | input | $clog2(THREADS+1) | Active threads in the issuing warp |
| rd_idx | input | 3 | Counter selected for readback |
| slot_cat | output | 8 | One-hot category of the current slot |
| rd_data | output | CNT_W | Registered value of the selected counter |

## Verification
The bench builds the block with THREADS = 8 and CNT_W = 6. The narrow counter saturates at 63, so a run of a few hundred cycles reaches saturation, and a long stream of full issues drives one counter into its hold state. Because the thread-count input is four bits wide while a warp holds eight threads, random stimulus also produces counts above THREADS, which exercises the inclusive full-issue comparison. Random flags with biased densities reach every branch of the tree, including those where lower-priority flags are set together with the winning one.

// File: rtl/isc_pkg.sv
package isc_pkg;

  localparam int NCAT  = 8;
  localparam int SEL_W = $clog2(NCAT);

  // Bit position in slot_cat and counter index; the bench depends on this.
  typedef enum logic [SEL_W-1:0] {
    CAT_SYNC    = 3'd0,
    CAT_MEMBAR  = 3'd1,
    CAT_ATOMIC  = 3'd2,
    CAT_CTRL    = 3'd3,
    CAT_FULL    = 3'd4,
    CAT_DIVERGE = 3'd5,
    CAT_SCORE   = 3'd6,
    CAT_PIPE    = 3'd7
  } slot_cat_e;

  typedef logic [NCAT-1:0] cat_vec_t;

endpackage

// File: rtl/isc_classify.sv
module isc_classify
  import isc_pkg::*;
#(
  parameter int THREADS = 32,
  parameter int ACT_W   = $clog2(THREADS+1)
) (
  input  logic             en,
  input  logic             any_valid,
  input  logic             sync_wait,
  input  logic             membar_wait,
  input  logic             atomic_wait,
  input  logic             sb_fail,
  input  logic             issued,
  input  logic [ACT_W-1:0] active_thr,
  output cat_vec_t         cat
);

  localparam logic [ACT_W-1:0] FULL_CNT = ACT_W'(THREADS);

  slot_cat_e sel;

  // Priority tree: idle reasons (R2, R3) versus work present (R4..R7)
  always_comb begin
    sel = CAT_CTRL;
    if (!any_valid) begin
      if (sync_wait)        sel = CAT_SYNC;
      else if (membar_wait) sel = CAT_MEMBAR;
      else if (atomic_wait) sel = CAT_ATOMIC;
      else                  sel = CAT_CTRL;
    end else if (issued) begin
      sel = (active_thr >= FULL_CNT) ? CAT_FULL : CAT_DIVERGE;
    end else if (sb_fail) begin
      sel = CAT_SCORE;
    end else begin
      sel = CAT_PIPE;
    end
  end

  always_comb begin
    cat = '0;
    if (en) cat[sel] = 1'b1;
  end

endmodule

// File: rtl/isc_sat_counter.sv
module isc_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] q_nxt;
  logic         q_ce;

  always_comb begin
    q_ce  = clr | (inc & (q != TOP));
    q_nxt = clr ? '0 : q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_ce) q <= q_nxt;
  end

endmodule

// File: rtl/isc_readout.sv
module isc_readout #(
  parameter int N     = 8,
  parameter int W     = 32,
  parameter int SEL_W = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0][W-1:0] cnt,
  input  logic [SEL_W-1:0]    sel,
  output logic [W-1:0]        q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = '0;
    for (int i = 0; i < N; i++) begin
      if (sel == SEL_W'(i)) q_nxt = cnt[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/issue_slot_classifier.sv
module issue_slot_classifier
  import isc_pkg::*;
#(
  parameter int THREADS = 32,
  parameter int CNT_W   = 32,
  localparam int ACT_W  = $clog2(THREADS+1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               count_en,
  input  logic               cnt_clr,
  input  logic               any_valid,
  input  logic               sync_wait,
  input  logic               membar_wait,
  input  logic               atomic_wait,
  input  logic               sb_fail,
  input  logic               issued,
  input  logic [ACT_W-1:0]   active_thr,
  input  logic [SEL_W-1:0]   rd_idx,
  output logic [NCAT-1:0]    slot_cat,
  output logic [CNT_W-1:0]   rd_data
);

  cat_vec_t                    cat;
  logic [NCAT-1:0][CNT_W-1:0]  cnt_arr;

  isc_classify #(
    .THREADS (THREADS),
    .ACT_W   (ACT_W)
  ) u_classify (
    .en          (count_en),
    .any_valid   (any_valid),
    .sync_wait   (sync_wait),
    .membar_wait (membar_wait),
    .atomic_wait (atomic_wait),
    .sb_fail     (sb_fail),
    .issued      (issued),
    .active_thr  (active_thr),
    .cat         (cat)
  );

  for (genvar g = 0; g < NCAT; g++) begin : g_cnt
    isc_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (cat[g]),
      .q     (cnt_arr[g])
    );
  end

  isc_readout #(
    .N     (NCAT),
    .W     (CNT_W),
    .SEL_W (SEL_W)
  ) u_readout (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (cnt_arr),
    .sel   (rd_idx),
    .q     (rd_data)
  );

  assign slot_cat = cat;

endmodule

// File: rtl/isc_checker.sv
module isc_checker #(
  parameter int THREADS = 32,
  parameter int CNT_W   = 32,
  localparam int ACT_W  = $clog2(THREADS+1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             count_en,
  input logic             cnt_clr,
  input logic             any_valid,
  input logic             sync_wait,
  input logic             membar_wait,
  input logic             atomic_wait,
  input logic             sb_fail,
  input logic             issued,
  input logic [ACT_W-1:0] active_thr,
  input logic [7:0]       slot_cat,
  input logic [CNT_W-1:0] rd_data
);

  a_r1_one_category: assert property (@(posedge clk) disable iff (!rst_n)
    count_en |-> ($countones(slot_cat) == 1));

  a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en |-> (slot_cat == '0));

  a_r2_sync_first: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !any_valid && sync_wait) |-> slot_cat[0]);

  a_r2_membar_over_atomic: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !any_valid && !sync_wait && membar_wait) |-> slot_cat[1]);

  a_r3_control_hazard: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !any_valid && !sync_wait && !membar_wait && !atomic_wait) |-> slot_cat[3]);

  a_r4_full_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && any_valid && issued && (active_thr >= ACT_W'(THREADS))) |-> slot_cat[4]);

  a_r5_divergent: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && any_valid && issued && (active_thr < ACT_W'(THREADS))) |-> slot_cat[5]);

  a_r6_scoreboard: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && any_valid && !issued && sb_fail) |-> slot_cat[6]);

  a_r7_pipe_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && any_valid && !issued && !sb_fail) |-> slot_cat[7]);

  a_r9_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |-> ##2 (rd_data == '0));

endmodule

bind issue_slot_classifier isc_checker #(
  .THREADS (THREADS),
  .CNT_W   (CNT_W)
) u_isc_checker (.*);

// File: tb/test_issue_slot_classifier.sv
module test_issue_slot_classifier;

  localparam int TH  = 8;
  localparam int CW  = 6;
  localparam int NC  = 8;
  localparam int AW  = $clog2(TH+1);
  localparam int SAT = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          count_en, cnt_clr;
  logic          any_valid, sync_wait, membar_wait, atomic_wait, sb_fail, issued;
  logic [AW-1:0] active_thr;
  logic [2:0]    rd_idx;
  logic [NC-1:0] slot_cat;
  logic [CW-1:0] rd_data;

  issue_slot_classifier #(.THREADS(TH), .CNT_W(CW)) i_issue_slot_classifier (
    .clk, .rst_n, .count_en, .cnt_clr, .any_valid, .sync_wait, .membar_wait,
    .atomic_wait, .sb_fail, .issued, .active_thr, .rd_idx, .slot_cat, .rd_data
  );

  initial forever #10 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cnt_m [NC];
  int rd_m  = 0;
  bit done  = 0;

  // Behavioural reference: category index, or -1 when counting is off
  function automatic int ref_cat();
    if (!count_en) return -1;
    if (!any_valid) begin
      if (sync_wait)   return 0;
      if (membar_wait) return 1;
      if (atomic_wait) return 2;
      return 3;
    end
    if (issued) return (int'(active_thr) >= TH) ? 4 : 5;
    return sb_fail ? 6 : 7;
  endfunction

  function automatic string tag_of(int c);
    case (c)
      -1: return "R1";
      0, 1, 2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic drive(bit en, bit clr, bit v, bit s, bit m, bit a, bit sb,
                       bit is, int act, int idx);
    count_en = en; cnt_clr = clr; any_valid = v; sync_wait = s;
    membar_wait = m; atomic_wait = a; sb_fail = sb; issued = is;
    active_thr = AW'(act); rd_idx = 3'(idx);
  endtask

  // Inputs already driven at the falling edge; check, then advance one edge.
  task automatic step();
    int c;
    logic [NC-1:0] ev;
    #2;
    c  = ref_cat();
    ev = (c < 0) ? '0 : (NC'(1) << c);
    n_cmp++;
    if (slot_cat !== ev) begin
      n_bad++;
      $display("FAIL %s slot_cat got %b exp %b", tag_of(c), slot_cat, ev);
    end
    n_cmp++;
    if (rd_data !== CW'(rd_m)) begin
      n_bad++;
      $display("FAIL R8/R9/R10 rd_data got %0d exp %0d", rd_data, rd_m);
    end
    @(posedge clk);
    rd_m = cnt_m[rd_idx];
    if (cnt_clr) begin
      foreach (cnt_m[i]) cnt_m[i] = 0;
    end else if (c >= 0 && cnt_m[c] < SAT) begin
      cnt_m[c]++;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1 got hung exp finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    foreach (cnt_m[i]) cnt_m[i] = 0;
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R10 reset state
    n_cmp++;
    if (rd_data !== '0 || slot_cat !== '0) begin
      n_bad++;
      $display("FAIL R10 reset got rd=%0d cat=%b exp 0", rd_data, slot_cat);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // Directed: each branch, lower-priority flags set alongside (R2..R7)
    drive(1, 0, 0, 1, 1, 1, 1, 1, TH, 0); step();     // R2 sync wins
    drive(1, 0, 0, 0, 1, 1, 1, 1, TH, 0); step();     // R2 membar
    drive(1, 0, 0, 0, 0, 1, 1, 1, TH, 1); step();     // R2 atomic
    drive(1, 0, 0, 0, 0, 0, 1, 1, TH, 2); step();     // R3 control
    drive(1, 0, 1, 1, 1, 1, 1, 1, TH, 3); step();     // R4 full, R6 sb ignored
    drive(1, 0, 1, 0, 0, 0, 0, 1, TH+3, 4); step();   // R4 above THREADS
    drive(1, 0, 1, 1, 0, 0, 1, 1, TH-1, 4); step();   // R5 divergence
    drive(1, 0, 1, 1, 1, 1, 1, 0, 0, 5); step();      // R6 scoreboard
    drive(1, 0, 1, 1, 1, 1, 0, 0, 0, 6); step();      // R7 pipe stall
    for (int i = 0; i < NC; i++) begin                // R10 readback of each
      drive(0, 0, 1, 0, 0, 0, 0, 1, TH, i); step();   // R1 no counting
    end

    // R8 saturation of the full-issue counter
    for (int i = 0; i < SAT + 10; i++) begin
      drive(1, 0, 1, 0, 0, 0, 0, 1, TH, 4); step();
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 4); step();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 4); step();

    // R9 clear wins over an increment, and acts with counting off
    drive(1, 1, 1, 0, 0, 0, 0, 1, TH, 4); step();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 4); step();
    drive(1, 0, 1, 0, 0, 0, 0, 1, 2, 5); step();
    drive(0, 1, 0, 0, 0, 0, 0, 0, 0, 5); step();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 5); step();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 5); step();

    // Random traffic with biased flag densities
    for (int i = 0; i < 6000; i++) begin
      drive(($urandom % 8) != 0, ($urandom % 300) == 0, ($urandom % 3) != 0,
            ($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 2) == 0,
            ($urandom % 2) == 0, ($urandom % 2) == 0,
            ($urandom % 3 == 0) ? TH : int'($urandom % 16), int'($urandom % 8));
      step();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule